// File: doc/BRIEF.md
# Segmented Wide XOR Reducer

This block folds a 96-bit operand into eight parity bits. The operand is the concatenation of two 48-bit input words, with the high word above the low word. A mode input chooses how the operand is cut. In fine mode the operand splits into eight equal 12-bit groups, and each group gives one result bit. In coarse mode the same group parities are combined into a nested set of spans: four 24-bit parities, two 48-bit parities and one parity over the whole 96 bits.

All eight bits are packed into one byte. That byte passes through an output register, which has a clock enable and a synchronous clear. A parameter can remove the register, which gives a combinational path with no latency. A function-enable input forces the value presented to the output stage to zero when the reducer is not in use.

Top module: `wide_xor_reducer`

## Requirements
- R1: In fine mode (`coarse` = 0), result bit i is the XOR of all bits of operand {word_hi, word_lo} in the range [12*i+11 : 12*i], for i = 0 to 7.
- R2: In coarse mode (`coarse` = 1), result bits 0, 2, 4 and 6 hold the XOR of operand bits [23:0], [47:24], [71:48] and [95:72], in that order.
- R3: In coarse mode, result bit 1 is the XOR of all of word_lo, and result bit 5 is the XOR of all of word_hi.
- R4: In coarse mode, result bit 3 is the XOR of all 96 operand bits, and result bit 7 is always 0.
- R5: While `xor_en` is low, the value captured by the output stage is all zeros, whatever the operand and mode.
- R6: With the default registered build, the result changes only at a rising clock edge where `ce` is high. It then shows the reduction of the inputs present at that edge, so the latency is one cycle.
- R7: While `ce` is low and `srst` is low, the result keeps its value, even when the operand, mode or enable change.
- R8: When `srst` is high at a rising edge, the result becomes zero after that edge, whether `ce` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| srst | input | 1 | Synchronous clear of the output register, active high; takes priority over `ce` |
| ce | input | 1 | Clock enable of the output register |
| xor_en | input | 1 | Function enable; when low the reducer presents zero |
| coarse | input | 1 | Grouping select: 0 gives eight 12-bit groups, 1 gives the 24/48/96-bit hierarchy |
| word_lo | input | 48 | Low half of the operand, bits [47:0] |
| word_hi | input | 48 | High half of the operand, bits [95:48] |
| result | output | 8 | Packed reduction result |

## Verification
If a group tap or a span combination is wired wrongly, one or more specific result bits flip. This shows at the first edge after an operand that has odd parity in the affected range. Random operands expose it almost at once, because each range then has odd parity half of the time.

A fault in the register control shows in other ways. A stuck enable leaves stale bytes after `ce` drops. A clear that loses priority leaves non-zero data after an `srst` edge with `ce` low. Both show on the first cycle after the stimulus.

// File: rtl/wxr_pkg.sv
package wxr_pkg;
   typedef enum logic {
      WXR_FINE   = 1'b0,
      WXR_COARSE = 1'b1
   } wxr_mode_e;

   localparam int WXR_RES_W = 8;
endpackage

// File: rtl/wxr_group_parity.sv
module wxr_group_parity #(
   parameter int OPER_W  = 96,
   parameter int GROUP_W = 12,
   localparam int NGRP   = OPER_W / GROUP_W
) (
   input  logic [OPER_W-1:0] oper,
   output logic [NGRP-1:0]   par
);
   if (OPER_W % GROUP_W != 0) begin : g_bad_split
      $error("wxr_group_parity: operand width must be a multiple of group width");
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign par[g] = ^oper[g*GROUP_W +: GROUP_W];
   end
endmodule

// File: rtl/wxr_span_mux.sv
module wxr_span_mux
   import wxr_pkg::*;
#(
   parameter int NGRP = 8,
   localparam int NQ  = NGRP / 2
) (
   input  logic [NGRP-1:0] grp,
   input  wxr_mode_e       mode,
   output logic [NGRP-1:0] y
);
   logic [NQ-1:0] quad;
   logic          half_lo, half_hi, whole;
   logic [NGRP-1:0] nest;

   if (NGRP != 8) begin : g_bad_n
      $error("wxr_span_mux: the nested packing needs exactly eight groups");
   end

   // pairs of adjacent groups make the 24-bit spans
   for (genvar k = 0; k < NQ; k++) begin : g_pair
      assign quad[k] = grp[2*k] ^ grp[2*k+1];
   end

   assign half_lo = quad[0] ^ quad[1];
   assign half_hi = quad[2] ^ quad[3];
   assign whole   = half_lo ^ half_hi;

   always_comb begin
      nest    = '0;
      nest[0] = quad[0];
      nest[2] = quad[1];
      nest[4] = quad[2];
      nest[6] = quad[3];
      nest[1] = half_lo;
      nest[5] = half_hi;
      nest[3] = whole;
      nest[7] = 1'b0;
   end

   assign y = (mode == WXR_COARSE) ? nest : grp;
endmodule

// File: rtl/wxr_out_stage.sv
module wxr_out_stage #(
   parameter int W          = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         srst,
   input  logic         ce,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("wxr_out_stage: width must be positive");
   end

   if (REGISTERED) begin : g_reg
      logic [W-1:0] q_r;

      always_ff @(posedge clk) begin
         if (srst)    q_r <= '0;
         else if (ce) q_r <= d;
      end
      assign q = q_r;

      // R8
      clr_chk: assert property (@(posedge clk) srst |=> (q == '0));
      // R7
      hold_chk: assert property (@(posedge clk) disable iff (srst)
         !ce |=> $stable(q));
      // R6
      load_chk: assert property (@(posedge clk) disable iff (srst)
         ce |=> (q == $past(d)));
   end else begin : g_comb
      assign q = d;
   end
endmodule

// File: rtl/wide_xor_reducer.sv
module wide_xor_reducer
   import wxr_pkg::*;
#(
   parameter int WORD_W     = 48,
   parameter int GROUP_W    = 12,
   parameter bit REGISTERED = 1'b1,
   localparam int OPER_W    = 2 * WORD_W,
   localparam int NGRP      = OPER_W / GROUP_W
) (
   input  logic              clk,
   input  logic              srst,
   input  logic              ce,
   input  logic              xor_en,
   input  logic              coarse,
   input  logic [WORD_W-1:0] word_lo,
   input  logic [WORD_W-1:0] word_hi,
   output logic [WXR_RES_W-1:0] result
);
   if (NGRP != WXR_RES_W) begin : g_bad_cfg
      $error("wide_xor_reducer: operand/group widths must give eight groups");
   end

   logic [OPER_W-1:0] oper;
   logic [NGRP-1:0]   grp_par;
   logic [NGRP-1:0]   packed_y;
   logic [NGRP-1:0]   gated;
   wxr_mode_e         mode;

   assign oper = {word_hi, word_lo};
   assign mode = wxr_mode_e'(coarse);

   wxr_group_parity #(.OPER_W(OPER_W), .GROUP_W(GROUP_W)) u_grp (
      .oper (oper),
      .par  (grp_par)
   );

   wxr_span_mux #(.NGRP(NGRP)) u_mux (
      .grp  (grp_par),
      .mode (mode),
      .y    (packed_y)
   );

   assign gated = xor_en ? packed_y : '0;

   wxr_out_stage #(.W(NGRP), .REGISTERED(REGISTERED)) u_out (
      .clk  (clk),
      .srst (srst),
      .ce   (ce),
      .d    (gated),
      .q    (result)
   );

   if (REGISTERED) begin : g_chk
      // R4
      pad_bit_chk: assert property (@(posedge clk) disable iff (srst)
         (ce && coarse) |=> !result[7]);
      // R4
      full_par_chk: assert property (@(posedge clk) disable iff (srst)
         (ce && coarse && xor_en) |=> (result[3] == $past(^oper)));
      // R5
      off_zero_chk: assert property (@(posedge clk) disable iff (srst)
         (ce && !xor_en) |=> (result == '0));
   end
endmodule

// File: tb/tb_wide_xor_reducer.sv
`timescale 1ns/1ps
module tb_wide_xor_reducer;
   logic        clk = 1'b0;
   logic        srst, ce, xor_en, coarse;
   logic [47:0] word_lo, word_hi;
   logic [7:0]  result;

   int n_run  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;  // 125 MHz

   wide_xor_reducer dut (
      .clk(clk), .srst(srst), .ce(ce), .xor_en(xor_en), .coarse(coarse),
      .word_lo(word_lo), .word_hi(word_hi), .result(result)
   );

   typedef struct packed {
      logic [47:0] lo;
      logic [47:0] hi;
      logic        crs;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      '{48'h0, 48'h0, 1'b0},
      '{48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 1'b0},
      '{48'h0000_0000_0001, 48'h0, 1'b0},
      '{48'h8000_0000_0000, 48'h0000_0000_0800, 1'b0},
      '{48'h0010_0200_3004, 48'h5006_0070_0800, 1'b0},
      '{48'h0, 48'h0, 1'b1},
      '{48'hFFFF_FFFF_FFFF, 48'h0, 1'b1},
      '{48'h0000_0000_0001, 48'h8000_0000_0000, 1'b1},
      '{48'h0000_0100_0000, 48'h0000_0000_0001, 1'b1},
      '{48'h1234_5678_9ABC, 48'hDEF0_1357_9BDF, 1'b1}
   };

   function automatic logic [7:0] ref_out(input logic [47:0] lo,
                                          input logic [47:0] hi,
                                          input logic crs);
      logic [95:0] op;
      logic [7:0]  e;
      op = {hi, lo};
      e  = '0;
      if (!crs) begin
         for (int i = 0; i < 8; i++) e[i] = ^op[12*i +: 12];
      end else begin
         e[0] = ^op[0 +: 24];
         e[2] = ^op[24 +: 24];
         e[4] = ^op[48 +: 24];
         e[6] = ^op[72 +: 24];
         e[1] = ^lo;
         e[5] = ^hi;
         e[3] = ^op;
         e[7] = 1'b0;
      end
      return e;
   endfunction

   task automatic check(input string req, input logic [7:0] got,
                        input logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: result=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic check_mode(input logic crs, input logic [7:0] exp);
      if (!crs) begin
         check("R1", result, exp);
      end else begin
         check("R2", result & 8'h55, exp & 8'h55);
         check("R3", result & 8'h22, exp & 8'h22);
         check("R4", result & 8'h88, exp & 8'h88);
      end
   endtask

   task automatic apply(input logic [47:0] lo, input logic [47:0] hi,
                        input logic crs);
      @(negedge clk);
      word_lo = lo; word_hi = hi; coarse = crs;
      @(negedge clk);
   endtask

   logic [7:0] held;

   initial begin
      srst = 1'b1; ce = 1'b0; xor_en = 1'b1; coarse = 1'b0;
      word_lo = '1; word_hi = '1;
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8", result, 8'h00);
      srst = 1'b0; ce = 1'b1;

      for (int v = 0; v < NVEC; v++) begin
         apply(VECS[v].lo, VECS[v].hi, VECS[v].crs);
         check_mode(VECS[v].crs, ref_out(VECS[v].lo, VECS[v].hi, VECS[v].crs));
      end

      for (int r = 0; r < 200; r++) begin
         logic [47:0] lo, hi;
         logic        crs;
         lo  = {$urandom(), $urandom()};
         hi  = {$urandom(), $urandom()};
         crs = r[0];
         apply(lo, hi, crs);
         check_mode(crs, ref_out(lo, hi, crs));
      end

      // R6: one-cycle latency, change seen only after the edge
      apply(48'h0, 48'h0, 1'b0);
      @(negedge clk);
      word_lo = 48'h0000_0000_0001;
      #1 check("R6", result, 8'h00);
      @(negedge clk);
      check("R6", result, 8'h01);

      // R7: ce low holds the result
      apply(48'h0000_0001_0001, 48'h0, 1'b0);
      held = result;
      ce = 1'b0;
      @(negedge clk);
      word_lo = 48'hFFF0_0000_0FFF; word_hi = 48'h0000_0000_0001; coarse = 1'b1;
      xor_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R7", result, held);
      xor_en = 1'b1;

      // R5: enable low gives zero
      ce = 1'b1;
      apply(48'hFFFF_FFFF_FFFE, 48'h0000_0000_0001, 1'b0);
      check("R1", result, ref_out(48'hFFFF_FFFF_FFFE, 48'h0000_0000_0001, 1'b0));
      @(negedge clk); xor_en = 1'b0;
      @(negedge clk);
      check("R5", result, 8'h00);
      coarse = 1'b1;
      @(negedge clk);
      check("R5", result, 8'h00);
      xor_en = 1'b1;
      @(negedge clk);
      check("R4", result, ref_out(word_lo, word_hi, 1'b1));

      // R8: clear wins over ce low
      ce = 1'b0; srst = 1'b1;
      @(negedge clk);
      check("R8", result, 8'h00);
      srst = 1'b0;
      @(negedge clk);
      check("R8", result, 8'h00);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule